// File: doc/BRIEF.md
# Calendar Time Counter with Daylight-Saving Adjustment

This block keeps wall-clock time and calendar date. It holds seven byte-wide fields: seconds, minutes, hours, day of week, day of month, month and a two-digit year. It advances them by one second on every pulse of a 1 Hz tick input. A three-bit mode word picks how the fields are encoded. They can be BCD or plain binary, and the hours can run on a 24-hour clock or on a 12-hour clock with a PM flag. The same mode word can also switch on automatic daylight-saving jumps, which take place on fixed Sundays in spring and in autumn.

A host loads any field, or the mode word, through a write port that uses a valid/ready handshake. A write is accepted in a cycle where both `wr_valid_i` and `wr_ready_o` are high. `wr_ready_o` drops in any cycle where a tick is present, because a tick has priority over a write. A write offered in that cycle is not taken. The host must hold `wr_valid_i` and its address and data until it sees ready high. Stored bytes are never re-encoded when the mode changes, so the host rewrites the time after changing the mode. Each tick also produces a one-cycle update-done strobe. The strobe coincides with the first cycle in which the new values are visible.

Top module: `cal_counter`

## Requirements
- R1: While `por_n` is low, and after it rises, the fields read 00 seconds, 00 minutes, hour byte 0x12 (12 AM), day of week 1, date 1, month 1, year 00, and the mode word reads 0. Only this reset or a host write changes the mode word.
- R2: Mode bit 0 selects the encoding: 0 means each field is packed BCD (for example 59 is 0x59), and 1 means plain binary (59 is 0x3B).
- R3: Mode bit 1 selects the hour format: 1 means 0..23, and 0 means a 12-hour clock. In 12-hour format, bit 7 of the hour byte marks PM and bits 6:0 hold 12, 1, 2 … 11 in the active encoding. After 11:59:59 AM comes 12 PM (BCD 0x92), and after 11:59:59 PM comes 12 AM (0x12).
- R4: Each tick adds one second, with carries from seconds to minutes to hours to day. Day of week counts 1..7 with Sunday = 1 and wraps from 7 to 1 at midnight.
- R5: The date wraps to 1 after the last day of its month: 30 days for April, June, September and November, 31 for the other months, and 29 for February when year mod 4 = 0, else 28. The month wraps from 12 to 1, and the year wraps from 99 to 00.
- R6: With mode bit 2 set, a tick at 1:59:59 AM on a Sunday (day of week 1) in April with date 1..7 moves the time to 3:00:00. On any other date the tick gives 2:00:00.
- R7: With mode bit 2 set, a tick at 1:59:59 AM on a Sunday in October with date 25..31 moves the time back to 1:00:00, and this happens only once. When 1:59:59 is reached again, the next tick gives 2:00:00. With mode bit 2 clear, neither jump of R6 or R7 occurs.
- R8: `upd_done_o` is high for exactly the one cycle after each clock edge that sampled `tick_i` high, and is low otherwise.
- R9: `wr_ready_o` is the inverse of `tick_i`. An accepted write to address 0..6 (seconds, minutes, hours, day of week, date, month, year) or to address 7 (mode: bit 0 binary, bit 1 24-hour, bit 2 daylight saving) is visible on the next cycle. A write offered during a tick is dropped. In a cycle with neither a tick nor an accepted write, no output field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-up reset, asynchronous |
| tick_i | input | 1 | One-second pulse, one cycle wide |
| wr_valid_i | input | 1 | Host write offered |
| wr_ready_o | output | 1 | Host write can be taken this cycle |
| wr_addr_i | input | 3 | Write target: 0..6 time fields, 7 mode |
| wr_data_i | input | 8 | Write data |
| sec_o | output | 8 | Seconds field |
| min_o | output | 8 | Minutes field |
| hour_o | output | 8 | Hours field (bit 7 = PM in 12-hour format) |
| dow_o | output | 8 | Day of week, 1 = Sunday |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year within the century |
| mode_o | output | 3 | Mode word: bit 0 binary, bit 1 24-hour, bit 2 daylight saving |
| upd_done_o | output | 1 | One-cycle pulse after each tick |

## Verification
Every result is due one cycle after its stimulus. A tick sampled at a rising edge shows its new time and `upd_done_o` after that same edge. An accepted write shows its byte after its own edge, while `wr_ready_o` follows `tick_i` within the same cycle. The bench drives inputs on falling edges, so a behavioural reference model updates on the rising edge that samples them. Every output is then compared with that model on the following falling edge. Named checks sample the daylight-saving jumps, the month and year wraps and the handshake conflict at the falling edge after the tick or write that causes them.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NF        = 7;  // time fields
  localparam int FW        = 7;  // binary value width
  localparam int EW        = 8;  // encoded byte width
  localparam int AW        = 3;  // write address width
  localparam int F_SEC     = 0;
  localparam int F_MIN     = 1;
  localparam int F_HOUR    = 2;
  localparam int F_DOW     = 3;
  localparam int F_DATE    = 4;
  localparam int F_MON     = 5;
  localparam int F_YEAR    = 6;
  localparam int MODE_ADDR = 7;

  typedef struct packed {
    logic dst;  // bit 2
    logic h24;  // bit 1
    logic bin;  // bit 0
  } cal_mode_t;

  function automatic logic [FW-1:0] bcd_to_bin(input logic [EW-1:0] v);
    logic [FW-1:0] hi;
    hi = {3'b000, v[7:4]};
    return FW'(hi * 7'd10 + {3'b000, v[3:0]});
  endfunction

  function automatic logic [EW-1:0] bin_to_bcd(input logic [FW-1:0] v);
    logic [FW-1:0] tens;
    logic [FW-1:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [FW-1:0] dec_field(input logic [EW-1:0] v, input logic bin);
    return bin ? v[FW-1:0] : bcd_to_bin(v);
  endfunction

  function automatic logic [EW-1:0] enc_field(input logic [FW-1:0] v, input logic bin);
    return bin ? {1'b0, v} : bin_to_bcd(v);
  endfunction

  function automatic logic [FW-1:0] dec_hour(input logic [EW-1:0] v, input cal_mode_t m);
    logic [FW-1:0] h;
    h = dec_field({1'b0, v[6:0]}, m.bin);
    if (m.h24) return h;
    return ((h == 7'd12) ? 7'd0 : h) + (v[7] ? 7'd12 : 7'd0);
  endfunction

  function automatic logic [EW-1:0] enc_hour(input logic [FW-1:0] h, input cal_mode_t m);
    logic [FW-1:0] h12;
    logic [EW-1:0] e;
    if (m.h24) return enc_field(h, m.bin);
    h12 = (h >= 7'd12) ? h - 7'd12 : h;
    if (h12 == 7'd0) h12 = 7'd12;
    e = enc_field(h12, m.bin);
    return {(h >= 7'd12), e[6:0]};
  endfunction

  function automatic logic [4:0] month_days(input logic [FW-1:0] mon, input logic [FW-1:0] yr);
    case (mon)
      7'd2:                      return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_decode.sv
module cal_decode
  import cal_pkg::*;
#(
  parameter int N_FIELDS = NF,
  parameter int HOUR_IDX = F_HOUR
) (
  input  logic [N_FIELDS-1:0][EW-1:0] enc_i,
  input  cal_mode_t                   mode_i,
  output logic [N_FIELDS-1:0][FW-1:0] val_o
);
  for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
    if (i == HOUR_IDX) begin : g_hour
      assign val_o[i] = dec_hour(enc_i[i], mode_i);
    end else begin : g_plain
      assign val_o[i] = dec_field(enc_i[i], mode_i.bin);
    end
  end
endmodule

// File: rtl/cal_encode.sv
module cal_encode
  import cal_pkg::*;
#(
  parameter int N_FIELDS = NF,
  parameter int HOUR_IDX = F_HOUR
) (
  input  logic [N_FIELDS-1:0][FW-1:0] val_i,
  input  cal_mode_t                   mode_i,
  output logic [N_FIELDS-1:0][EW-1:0] enc_o
);
  for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
    if (i == HOUR_IDX) begin : g_hour
      assign enc_o[i] = enc_hour(val_i[i], mode_i);
    end else begin : g_plain
      assign enc_o[i] = enc_field(val_i[i], mode_i.bin);
    end
  end
endmodule

// File: rtl/cal_advance.sv
module cal_advance
  import cal_pkg::*;
#(
  parameter int YEAR_SPAN    = 100,
  parameter int SEC_PER_MIN  = 60,
  parameter int MIN_PER_HOUR = 60,
  parameter int HOUR_PER_DAY = 24,
  parameter int DAYS_PER_WK  = 7,
  parameter int SUNDAY_CODE  = 1,
  parameter int SPRING_MON   = 4,
  parameter int FALL_MON     = 10,
  parameter int FALL_MON_LEN = 31,
  parameter int JUMP_HOUR    = 1
) (
  input  logic [NF-1:0][FW-1:0] cur_i,
  input  logic                  dst_i,
  input  logic                  fb_done_i,
  output logic [NF-1:0][FW-1:0] nxt_o,
  output logic                  fb_set_o,
  output logic                  fb_clr_o
);
  localparam logic [FW-1:0] SEC_LAST  = FW'(SEC_PER_MIN - 1);
  localparam logic [FW-1:0] MIN_LAST  = FW'(MIN_PER_HOUR - 1);
  localparam logic [FW-1:0] HOUR_LAST = FW'(HOUR_PER_DAY - 1);
  localparam logic [FW-1:0] YEAR_LAST = FW'(YEAR_SPAN - 1);
  localparam logic [FW-1:0] DOW_LAST  = FW'(DAYS_PER_WK);
  localparam logic [FW-1:0] FIRST_WK_END  = FW'(DAYS_PER_WK);
  localparam logic [FW-1:0] LAST_WK_START = FW'(FALL_MON_LEN - DAYS_PER_WK + 1);

  logic [FW-1:0] s, mn, hr, dw, dt, mo, yr;
  logic          at_jump_time, sunday, spring, fall;

  always_comb begin
    s  = cur_i[F_SEC];
    mn = cur_i[F_MIN];
    hr = cur_i[F_HOUR];
    dw = cur_i[F_DOW];
    dt = cur_i[F_DATE];
    mo = cur_i[F_MON];
    yr = cur_i[F_YEAR];

    at_jump_time = (hr == FW'(JUMP_HOUR)) && (mn == MIN_LAST) && (s == SEC_LAST);
    sunday       = (dw == FW'(SUNDAY_CODE));
    spring = dst_i && sunday && at_jump_time && (mo == FW'(SPRING_MON)) && (dt <= FIRST_WK_END);
    fall   = dst_i && sunday && at_jump_time && (mo == FW'(FALL_MON)) && (dt >= LAST_WK_START)
             && !fb_done_i;

    nxt_o    = cur_i;
    fb_set_o = 1'b0;
    fb_clr_o = 1'b0;

    if (spring) begin
      nxt_o[F_SEC]  = '0;
      nxt_o[F_MIN]  = '0;
      nxt_o[F_HOUR] = FW'(JUMP_HOUR + 2);
    end else if (fall) begin
      nxt_o[F_SEC] = '0;
      nxt_o[F_MIN] = '0;
      fb_set_o     = 1'b1;
    end else if (s != SEC_LAST) begin
      nxt_o[F_SEC] = s + 7'd1;
    end else begin
      nxt_o[F_SEC] = '0;
      if (mn != MIN_LAST) begin
        nxt_o[F_MIN] = mn + 7'd1;
      end else begin
        nxt_o[F_MIN] = '0;
        fb_clr_o     = 1'b1;
        if (hr != HOUR_LAST) begin
          nxt_o[F_HOUR] = hr + 7'd1;
        end else begin
          nxt_o[F_HOUR] = '0;
          nxt_o[F_DOW]  = (dw >= DOW_LAST) ? 7'd1 : dw + 7'd1;
          if (dt < {2'b00, month_days(mo, yr)}) begin
            nxt_o[F_DATE] = dt + 7'd1;
          end else begin
            nxt_o[F_DATE] = 7'd1;
            if (mo < 7'd12) begin
              nxt_o[F_MON] = mo + 7'd1;
            end else begin
              nxt_o[F_MON]  = 7'd1;
              nxt_o[F_YEAR] = (yr >= YEAR_LAST) ? 7'd0 : yr + 7'd1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
#(
  parameter int YEAR_SPAN = 100
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          tick_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [EW-1:0] wr_data_i,
  output logic [EW-1:0] sec_o,
  output logic [EW-1:0] min_o,
  output logic [EW-1:0] hour_o,
  output logic [EW-1:0] dow_o,
  output logic [EW-1:0] date_o,
  output logic [EW-1:0] month_o,
  output logic [EW-1:0] year_o,
  output logic [2:0]    mode_o,
  output logic          upd_done_o
);
  localparam logic [EW-1:0] RST_HOUR = 8'h12;  // 12 AM in BCD 12-hour form
  localparam logic [EW-1:0] RST_ONE  = 8'h01;

  logic [NF-1:0][EW-1:0] tm_q;
  logic [NF-1:0][FW-1:0] cur_val, nxt_val;
  logic [NF-1:0][EW-1:0] nxt_enc;
  cal_mode_t             mode_q;
  logic                  fb_q, upd_q, fb_set, fb_clr;

  cal_decode #(.N_FIELDS(NF), .HOUR_IDX(F_HOUR)) u_dec (
    .enc_i (tm_q),
    .mode_i(mode_q),
    .val_o (cur_val)
  );

  cal_advance #(.YEAR_SPAN(YEAR_SPAN)) u_adv (
    .cur_i    (cur_val),
    .dst_i    (mode_q.dst),
    .fb_done_i(fb_q),
    .nxt_o    (nxt_val),
    .fb_set_o (fb_set),
    .fb_clr_o (fb_clr)
  );

  cal_encode #(.N_FIELDS(NF), .HOUR_IDX(F_HOUR)) u_enc (
    .val_i (nxt_val),
    .mode_i(mode_q),
    .enc_o (nxt_enc)
  );

  assign wr_ready_o = ~tick_i;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      tm_q         <= '0;
      tm_q[F_HOUR] <= RST_HOUR;
      tm_q[F_DOW]  <= RST_ONE;
      tm_q[F_DATE] <= RST_ONE;
      tm_q[F_MON]  <= RST_ONE;
      mode_q       <= '0;
      fb_q         <= 1'b0;
      upd_q        <= 1'b0;
    end else begin
      upd_q <= tick_i;
      if (tick_i) begin
        tm_q <= nxt_enc;
        if (fb_set)      fb_q <= 1'b1;
        else if (fb_clr) fb_q <= 1'b0;
      end else if (wr_valid_i) begin
        if (wr_addr_i == AW'(MODE_ADDR)) mode_q <= cal_mode_t'(wr_data_i[2:0]);
        else                             tm_q[wr_addr_i] <= wr_data_i;
      end
    end
  end

  assign sec_o      = tm_q[F_SEC];
  assign min_o      = tm_q[F_MIN];
  assign hour_o     = tm_q[F_HOUR];
  assign dow_o      = tm_q[F_DOW];
  assign date_o     = tm_q[F_DATE];
  assign month_o    = tm_q[F_MON];
  assign year_o     = tm_q[F_YEAR];
  assign mode_o     = mode_q;
  assign upd_done_o = upd_q;
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic       clk,
  input logic       por_n,
  input logic       tick_i,
  input logic       wr_valid_i,
  input logic       wr_ready_o,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic [2:0] mode_o,
  input logic       upd_done_o
);
  // R8: strobe follows every tick
  a_r8_strobe_after_tick: assert property (@(posedge clk) disable iff (!por_n)
    tick_i |=> upd_done_o);

  // R8: no strobe without a tick
  a_r8_no_spurious_strobe: assert property (@(posedge clk) disable iff (!por_n)
    !tick_i |=> !upd_done_o);

  // R9: idle cycles leave every field untouched
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!por_n)
    (!tick_i && !(wr_valid_i && wr_ready_o)) |=>
      $stable({sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, mode_o}));

  // R1: a tick never alters the mode word
  a_r1_mode_kept_on_tick: assert property (@(posedge clk) disable iff (!por_n)
    tick_i |=> $stable(mode_o));

  // R4: day of week stays inside 1..7 across a tick
  a_r4_dow_range: assert property (@(posedge clk) disable iff (!por_n)
    (tick_i && dow_o >= 8'd1 && dow_o <= 8'd7) |=> (dow_o >= 8'd1 && dow_o <= 8'd7));
endmodule

bind cal_counter cal_checker u_cal_checker (.*);

// File: tb/test_cal_counter.sv
module test_cal_counter;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, upd_done;
  logic [7:0] sec, mins, hour, dow, date, month, year;
  logic [2:0] mode;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  cal_counter i_cal_counter (
    .clk(clk), .por_n(por_n), .tick_i(tick), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .sec_o(sec), .min_o(mins), .hour_o(hour),
    .dow_o(dow), .date_o(date), .month_o(month), .year_o(year), .mode_o(mode),
    .upd_done_o(upd_done)
  );

  // ---------------- reference model ----------------
  logic [7:0] m_reg [7];
  logic [2:0] m_mode;
  bit         m_fb;
  bit         m_upd;

  function automatic int dec(int v, bit b);
    return b ? v : (v / 16) * 10 + (v % 16);
  endfunction

  function automatic int enc(int v, bit b);
    return b ? v : (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    bit b, h24, dst;
    int s, mi, hr, dw, dt, mo, yr, h12;
    b = m_mode[0]; h24 = m_mode[1]; dst = m_mode[2];
    s  = dec(m_reg[0], b);
    mi = dec(m_reg[1], b);
    hr = dec(m_reg[2] & 8'h7f, b);
    if (!h24) hr = (hr % 12) + (m_reg[2][7] ? 12 : 0);
    dw = dec(m_reg[3], b);
    dt = dec(m_reg[4], b);
    mo = dec(m_reg[5], b);
    yr = dec(m_reg[6], b);
    if (dst && mo == 4 && dw == 1 && dt <= 7 && hr == 1 && mi == 59 && s == 59) begin
      hr = 3; mi = 0; s = 0;
    end else if (dst && mo == 10 && dw == 1 && dt + 7 > 31 && hr == 1 && mi == 59 && s == 59 && !m_fb) begin
      mi = 0; s = 0; m_fb = 1;
    end else begin
      s++;
      if (s == 60) begin
        s = 0; mi++;
        if (mi == 60) begin
          mi = 0; m_fb = 0; hr++;
          if (hr == 24) begin
            hr = 0; dw = dw % 7 + 1; dt++;
            if (dt > mdays(mo, yr)) begin
              dt = 1; mo++;
              if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
            end
          end
        end
      end
    end
    m_reg[0] = 8'(enc(s, b));
    m_reg[1] = 8'(enc(mi, b));
    if (h24) m_reg[2] = 8'(enc(hr, b));
    else begin
      h12 = hr % 12;
      if (h12 == 0) h12 = 12;
      m_reg[2] = 8'(enc(h12, b) + (hr >= 12 ? 128 : 0));
    end
    m_reg[3] = 8'(enc(dw, b));
    m_reg[4] = 8'(enc(dt, b));
    m_reg[5] = 8'(enc(mo, b));
    m_reg[6] = 8'(enc(yr, b));
  endtask

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_reg[0] = 8'h00; m_reg[1] = 8'h00; m_reg[2] = 8'h12; m_reg[3] = 8'h01;
      m_reg[4] = 8'h01; m_reg[5] = 8'h01; m_reg[6] = 8'h00;
      m_mode = 3'b000; m_fb = 0; m_upd = 0;
    end else begin
      m_upd = tick;
      if (tick) model_tick();
      else if (wr_valid) begin
        if (wr_addr == 3'd7) m_mode = wr_data[2:0];
        else m_reg[wr_addr] = wr_data;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (por_n && cmp_on) begin
      chk(cur_req, "sec", sec, m_reg[0]);
      chk(cur_req, "min", mins, m_reg[1]);
      chk(cur_req, "hour", hour, m_reg[2]);
      chk(cur_req, "dow", dow, m_reg[3]);
      chk(cur_req, "date", date, m_reg[4]);
      chk(cur_req, "month", month, m_reg[5]);
      chk(cur_req, "year", year, m_reg[6]);
      chk(cur_req, "mode", mode, m_mode);
      chk("R8", "upd_done", upd_done, m_upd);
      chk("R9", "wr_ready", wr_ready, !tick);
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic set_all(input logic [7:0] md, input logic [7:0] h, input logic [7:0] mi,
                         input logic [7:0] s, input logic [7:0] dw, input logic [7:0] dt,
                         input logic [7:0] mo, input logic [7:0] yr);
    wr(3'd7, md); wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
    wr(3'd3, dw); wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1;
      @(negedge clk);
      tick = 0;
      @(negedge clk);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", "reset sec", sec, 8'h00);
    chk("R1", "reset hour", hour, 8'h12);
    chk("R1", "reset dow", dow, 8'h01);
    chk("R1", "reset date", date, 8'h01);
    chk("R1", "reset month", month, 8'h01);
    chk("R1", "reset year", year, 8'h00);
    chk("R1", "reset mode", mode, 3'b000);
    cmp_on = 1;

    // R4 / R5: BCD 24h, New Year rollover including year 99 -> 00
    cur_req = "R4";
    set_all(8'h02, 8'h23, 8'h59, 8'h58, 8'h07, 8'h31, 8'h12, 8'h99);
    tk(1);
    chk("R4", "sec 59", sec, 8'h59);
    tick = 1; @(negedge clk);
    chk("R8", "strobe after tick", upd_done, 1);
    tick = 0; @(negedge clk);
    chk("R8", "strobe one cycle", upd_done, 0);
    chk("R4", "hour wrap", hour, 8'h00);
    chk("R4", "dow wrap", dow, 8'h01);
    chk("R5", "date wrap", date, 8'h01);
    chk("R5", "month wrap", month, 8'h01);
    chk("R5", "year wrap", year, 8'h00);

    // R5: leap and non-leap February, 30-day month
    cur_req = "R5";
    set_all(8'h02, 8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h24);
    tk(1);
    chk("R5", "leap feb 29", date, 8'h29);
    chk("R5", "leap month", month, 8'h02);
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59); wr(3'd4, 8'h28); wr(3'd6, 8'h23);
    tk(1);
    chk("R5", "non-leap mar 1 date", date, 8'h01);
    chk("R5", "non-leap mar 1 month", month, 8'h03);
    set_all(8'h02, 8'h23, 8'h59, 8'h59, 8'h02, 8'h30, 8'h04, 8'h10);
    tk(1);
    chk("R5", "april 30 -> may 1", {month, date}, 16'h0501);

    // R3: BCD 12-hour
    cur_req = "R3";
    set_all(8'h00, 8'h11, 8'h59, 8'h59, 8'h02, 8'h05, 8'h06, 8'h20);
    tk(1);
    chk("R3", "11AM -> 12PM", hour, 8'h92);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tk(1);
    chk("R3", "12PM -> 1PM", hour, 8'h81);
    wr(3'd2, 8'h91); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tk(1);
    chk("R3", "11PM -> 12AM", hour, 8'h12);
    chk("R4", "midnight date step", date, 8'h06);

    // R2: binary 24h and binary 12h
    cur_req = "R2";
    set_all(8'h03, 8'h0f, 8'h3b, 8'h3b, 8'h04, 8'h1f, 8'h0c, 8'h63);
    tk(1);
    chk("R2", "binary hour 16", hour, 8'h10);
    chk("R2", "binary min 0", mins, 8'h00);
    wr(3'd2, 8'h17); wr(3'd1, 8'h3b); wr(3'd0, 8'h3b);
    tk(1);
    chk("R2", "binary year wrap", year, 8'h00);
    chk("R2", "binary month wrap", month, 8'h01);
    set_all(8'h01, 8'h8b, 8'h3b, 8'h3b, 8'h04, 8'h0a, 8'h03, 8'h15);
    tk(1);
    chk("R3", "binary 11PM -> 12AM", hour, 8'h0c);

    // R6: spring forward
    cur_req = "R6";
    set_all(8'h06, 8'h01, 8'h59, 8'h59, 8'h01, 8'h02, 8'h04, 8'h22);
    tk(1);
    chk("R6", "spring jump", {hour, mins, sec}, 24'h030000);
    set_all(8'h06, 8'h01, 8'h59, 8'h59, 8'h01, 8'h08, 8'h04, 8'h22);
    tk(1);
    chk("R6", "no jump second week", {hour, mins, sec}, 24'h020000);
    set_all(8'h04, 8'h01, 8'h59, 8'h59, 8'h01, 8'h07, 8'h04, 8'h22);
    tk(1);
    chk("R6", "spring jump 12h", hour, 8'h03);

    // R7: fall back once
    cur_req = "R7";
    set_all(8'h06, 8'h01, 8'h59, 8'h59, 8'h01, 8'h27, 8'h10, 8'h22);
    tk(1);
    chk("R7", "fall back", {hour, mins, sec}, 24'h010000);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tk(1);
    chk("R7", "no second fall back", {hour, mins, sec}, 24'h020000);
    set_all(8'h02, 8'h01, 8'h59, 8'h59, 8'h01, 8'h27, 8'h10, 8'h22);
    tk(1);
    chk("R7", "dst off no jump", hour, 8'h02);
    set_all(8'h06, 8'h01, 8'h59, 8'h59, 8'h01, 8'h20, 8'h10, 8'h22);
    tk(1);
    chk("R7", "not last week", hour, 8'h02);

    // R9: write during tick is dropped; mode held by ticks
    cur_req = "R9";
    set_all(8'h02, 8'h10, 8'h20, 8'h30, 8'h02, 8'h10, 8'h05, 8'h21);
    tick = 1; wr_valid = 1; wr_addr = 3'd0; wr_data = 8'h45;
    @(negedge clk);
    tick = 0; wr_valid = 0;
    chk("R9", "write dropped during tick", sec, 8'h31);
    chk("R9", "mode kept", mode, 3'b010);
    wr(3'd0, 8'h45);
    chk("R9", "write accepted", sec, 8'h45);

    // mixed run: random tick density near a day boundary
    cur_req = "R4";
    set_all(8'h02, 8'h23, 8'h40, 8'h00, 8'h07, 8'h28, 8'h02, 8'h23);
    for (int i = 0; i < 3000; i++) begin
      tick = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    tick = 0;
    @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule